// File: doc/BRIEF.md
# SMBus Packet Error Check Receive Checker

This block sits beside the byte engine of an I2C/SMBus target. The byte engine does the bit timing. It reports each finished byte with a one-cycle strobe, and it reports START and STOP conditions as one-cycle pulses. The checker keeps a running CRC-8 over every byte of the current transfer, including the address byte and any bytes the local side sends. It then tells the byte engine, through an acknowledge-valid strobe and a NAK level, whether the next acknowledge slot should carry ACK or NAK.

Software can arm a one-shot control that marks the next received byte as the packet error check byte. That byte is compared with the CRC gathered so far. A match is acknowledged according to the normal acknowledge enable. A mismatch is always refused with NAK and sets a sticky error flag, which stays set until software clears it.

The CRC generator has two structures, chosen by a parameter: a bit-serial XOR chain and a nibble table chain. Both compute the same value.

Top module: `pec_rx_checker`

## Requirements
- R1: The running CRC is CRC-8 with generator x^8+x^2+x+1 (0x07), start value 0x00 and no bit reflection. It is computed most-significant bit first over every byte strobed between a START and the following STOP, in both directions. Over the ASCII bytes "123456789" it gives 0xF4.
- R2: Every START, including a repeated START, reloads the running CRC to 0x00, so the check byte of a new transfer covers only the bytes after that START.
- R3: A pulse on `pec_arm_i` makes `pec_armed_o` read 1 from the next cycle. The next byte received while armed is the check byte. Taking that byte clears `pec_armed_o` one cycle after its strobe.
- R4: A START clears `pec_armed_o`, and so does reset. If `pec_arm_i` and `start_i` are high in the same cycle, the arm wins.
- R5: A byte strobed with `rx_mode_i` = 0 (local side transmitting) raises no `ack_vld_o`, leaves `pec_armed_o` unchanged, is never compared and never sets `crc_err_o`. It still enters the CRC.
- R6: For an ordinary received byte, `ack_vld_o` is high for exactly the cycle after the byte strobe, and `nak_o` = NOT `ack_en_i` (1 = send NAK).
- R7: A check byte equal to the running CRC is answered like a data byte (`nak_o` = NOT `ack_en_i`) and leaves `crc_err_o` unchanged.
- R8: A check byte that differs from the running CRC is answered with `nak_o` = 1 whatever `ack_en_i` is, and sets `crc_err_o` in the same cycle.
- R9: `crc_err_o` stays 1 until a pulse on `err_clr_i` or reset clears it. A new mismatch in the same cycle as a clear leaves it set.
- R10: A byte strobe outside a transfer (after STOP, or before the first START) is ignored: no `ack_vld_o`, and no change to the CRC.
- R11: All outputs are registered and respond exactly one clock after the input that causes them. After reset all outputs read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | START or repeated START seen, one-cycle pulse |
| stop_i | input | 1 | STOP seen, one-cycle pulse |
| byte_vld_i | input | 1 | A byte finished on the bus, one-cycle strobe |
| byte_i | input | BYTE_W (8) | Byte value, MSB first on the wire |
| rx_mode_i | input | 1 | 1 = the byte was received by this side, 0 = sent by it |
| pec_arm_i | input | 1 | Software pulse: the next received byte is the check byte |
| ack_en_i | input | 1 | 1 = acknowledge accepted bytes, 0 = answer NAK |
| err_clr_i | input | 1 | Software pulse that clears the CRC error flag |
| ack_vld_o | output | 1 | The acknowledge decision for the last received byte is valid |
| nak_o | output | 1 | 1 = send NAK in the acknowledge slot, 0 = send ACK |
| pec_armed_o | output | 1 | Read-back of the one-shot check-byte control |
| crc_err_o | output | 1 | Sticky flag: a check byte mismatched |

## Verification
Every result of this block is due one clock after its cause. This holds for the acknowledge strobe and NAK level after a byte strobe, for the error flag after a check byte or a clear pulse, and for the armed read-back after an arm pulse, a START or a consumed check byte. The bench drives each stimulus on a falling edge and holds it for exactly one rising edge. It then samples all outputs 1 ns after that edge, before the next stimulus, so each check sees the response of exactly one input cycle. The expected check-byte values come from a CRC model in the bench that is fed the same byte stream, and one fixed check value (0xF4 over "123456789") anchors that model to the generator.

// File: rtl/pec_pkg.sv
package pec_pkg;

   // CRC generator structures
   localparam int unsigned ARCH_BITWISE = 0;
   localparam int unsigned ARCH_NIBBLE  = 1;

   // Advance a CRC of 'width' bits by 'nbits' message bits, MSB first.
   // The message bits are the low 'nbits' bits of 'data'.
   function automatic logic [31:0] crc_bits(input logic [31:0] crc_in,
                                            input logic [31:0] poly,
                                            input logic [31:0] data,
                                            input int unsigned width,
                                            input int unsigned nbits);
      logic [31:0] c;
      logic [31:0] mask;
      logic        fb;
      mask = (width >= 32) ? 32'hFFFF_FFFF : ((32'd1 << width) - 32'd1);
      c    = crc_in & mask;
      for (int unsigned i = 0; i < 32; i++) begin
         if (i < nbits) begin
            fb = c[width-1] ^ data[nbits-1-i];
            c  = (c << 1) & mask;
            if (fb) c = c ^ (poly & mask);
         end
      end
      return c;
   endfunction

endpackage

// File: rtl/pec_crc_unit.sv
module pec_crc_unit
   import pec_pkg::*;
#(
   parameter int unsigned CRC_W    = 8,
   parameter int unsigned BYTE_W   = 8,
   parameter int unsigned POLY     = 32'h07,
   parameter int unsigned INIT     = 32'h00,
   parameter int unsigned CRC_ARCH = ARCH_BITWISE
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear_i,
   input  logic              upd_i,
   input  logic [BYTE_W-1:0] data_i,
   output logic [CRC_W-1:0]  crc_o
);

   localparam logic [31:0]      POLY32 = 32'(POLY);
   localparam logic [31:0]      INIT32 = 32'(INIT);
   localparam logic [CRC_W-1:0] INIT_V = INIT32[CRC_W-1:0];
   localparam int unsigned      NIBS   = BYTE_W / 4;

   logic [CRC_W-1:0] crc_q;
   logic [CRC_W-1:0] crc_nxt;

   generate
      if (CRC_ARCH == ARCH_NIBBLE) begin : g_nibble
         logic [CRC_W-1:0] tbl   [16];
         logic [CRC_W-1:0] stage [NIBS+1];

         for (genvar k = 0; k < 16; k++) begin : g_tbl
            localparam logic [31:0] TV =
               crc_bits(32'(k) << (CRC_W-4), POLY32, 32'd0, CRC_W, 4);
            assign tbl[k] = TV[CRC_W-1:0];
         end

         assign stage[0] = crc_q;
         for (genvar j = 0; j < NIBS; j++) begin : g_chain
            logic [3:0] idx;
            assign idx = stage[j][CRC_W-1 -: 4] ^ data_i[BYTE_W-1-4*j -: 4];
            assign stage[j+1] = (stage[j] << 4) ^ tbl[idx];
         end
         assign crc_nxt = stage[NIBS];
      end else begin : g_bitwise
         logic [31:0] wide;
         always_comb begin
            wide    = crc_bits(32'(crc_q), POLY32, 32'(data_i), CRC_W, BYTE_W);
            crc_nxt = wide[CRC_W-1:0];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       crc_q <= INIT_V;
      else if (clear_i) crc_q <= INIT_V;
      else if (upd_i)   crc_q <= crc_nxt;
   end

   assign crc_o = crc_q;

   AST_START_RELOADS_CRC: assert property (@(posedge clk) disable iff (!rst_n)
      clear_i |=> (crc_q == INIT_V)) else $error("crc not reloaded"); // R2
   AST_CRC_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!clear_i && !upd_i) |=> $stable(crc_q)) else $error("crc moved"); // R10

endmodule

// File: rtl/pec_arm_ctrl.sv
module pec_arm_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic stop_i,
   input  logic byte_vld_i,
   input  logic rx_mode_i,
   input  logic arm_set_i,
   output logic accept_o,
   output logic rx_accept_o,
   output logic check_pec_o,
   output logic armed_o
);

   logic busy_q;
   logic armed_q;

   // A byte counts only inside a transfer; a START in the same cycle wins.
   assign accept_o    = byte_vld_i && busy_q && !start_i;
   assign rx_accept_o = accept_o && rx_mode_i;
   assign check_pec_o = rx_accept_o && armed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       busy_q <= 1'b0;
      else if (start_i) busy_q <= 1'b1;
      else if (stop_i)  busy_q <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           armed_q <= 1'b0;
      else if (arm_set_i)   armed_q <= 1'b1;
      else if (start_i)     armed_q <= 1'b0;
      else if (check_pec_o) armed_q <= 1'b0;
   end

   assign armed_o = armed_q;

   AST_START_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !arm_set_i) |=> !armed_q) else $error("arm survived start"); // R4
   AST_ARM_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
      (check_pec_o && !arm_set_i) |=> !armed_q) else $error("arm not consumed"); // R3
   AST_TX_KEEPS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
      (armed_q && byte_vld_i && !rx_mode_i && !start_i) |=> armed_q)
      else $error("tx byte touched arm"); // R5

endmodule

// File: rtl/pec_ack_decide.sv
module pec_ack_decide #(
   parameter int unsigned BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_accept_i,
   input  logic              check_pec_i,
   input  logic [BYTE_W-1:0] byte_i,
   input  logic [BYTE_W-1:0] crc_i,
   input  logic              ack_en_i,
   input  logic              err_clr_i,
   output logic              ack_vld_o,
   output logic              nak_o,
   output logic              err_o
);

   logic mismatch;
   logic bad_pec;
   logic ack_vld_q;
   logic nak_q;
   logic err_q;

   assign mismatch = (byte_i != crc_i);
   assign bad_pec  = check_pec_i && mismatch;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ack_vld_q <= 1'b0;
         nak_q     <= 1'b0;
      end else begin
         ack_vld_q <= rx_accept_i;
         if (rx_accept_i) nak_q <= bad_pec ? 1'b1 : !ack_en_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         err_q <= 1'b0;
      else if (bad_pec)   err_q <= 1'b1;
      else if (err_clr_i) err_q <= 1'b0;
   end

   assign ack_vld_o = ack_vld_q;
   assign nak_o     = nak_q;
   assign err_o     = err_q;

   AST_NO_ACK_ON_TX: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_accept_i |=> !ack_vld_q) else $error("ack for non-rx byte"); // R5
   AST_DATA_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_accept_i && !check_pec_i) |=> (ack_vld_q && (nak_q == !$past(ack_en_i))))
      else $error("data ack wrong"); // R6
   AST_BAD_PEC_NAK: assert property (@(posedge clk) disable iff (!rst_n)
      (check_pec_i && (byte_i != crc_i)) |=> (ack_vld_q && nak_q && err_q))
      else $error("bad check byte accepted"); // R8
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (err_q && !err_clr_i) |=> err_q) else $error("error flag dropped"); // R9

endmodule

// File: rtl/pec_rx_checker.sv
module pec_rx_checker
   import pec_pkg::*;
#(
   parameter int unsigned BYTE_W   = 8,
   parameter int unsigned CRC_W    = 8,
   parameter int unsigned POLY     = 32'h07,
   parameter int unsigned INIT     = 32'h00,
   parameter int unsigned CRC_ARCH = ARCH_BITWISE
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              stop_i,
   input  logic              byte_vld_i,
   input  logic [BYTE_W-1:0] byte_i,
   input  logic              rx_mode_i,
   input  logic              pec_arm_i,
   input  logic              ack_en_i,
   input  logic              err_clr_i,
   output logic              ack_vld_o,
   output logic              nak_o,
   output logic              pec_armed_o,
   output logic              crc_err_o
);

   // Elaboration-time parameter checks
   generate
      if (CRC_W != BYTE_W) begin : g_chk_width
         $error("CRC width must equal byte width for the check-byte compare");
      end
      if (CRC_W < 4 || CRC_W > 31) begin : g_chk_crc_range
         $error("CRC width out of supported range");
      end
      if (CRC_ARCH != ARCH_BITWISE && CRC_ARCH != ARCH_NIBBLE) begin : g_chk_arch
         $error("unknown CRC structure");
      end
      if (CRC_ARCH == ARCH_NIBBLE && (BYTE_W % 4) != 0) begin : g_chk_nib
         $error("nibble structure needs byte width divisible by four");
      end
   endgenerate

   logic             accept;
   logic             rx_accept;
   logic             check_pec;
   logic [CRC_W-1:0] crc;

   pec_arm_ctrl u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .stop_i     (stop_i),
      .byte_vld_i (byte_vld_i),
      .rx_mode_i  (rx_mode_i),
      .arm_set_i  (pec_arm_i),
      .accept_o   (accept),
      .rx_accept_o(rx_accept),
      .check_pec_o(check_pec),
      .armed_o    (pec_armed_o)
   );

   pec_crc_unit #(
      .CRC_W   (CRC_W),
      .BYTE_W  (BYTE_W),
      .POLY    (POLY),
      .INIT    (INIT),
      .CRC_ARCH(CRC_ARCH)
   ) u_crc (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear_i(start_i),
      .upd_i  (accept),
      .data_i (byte_i),
      .crc_o  (crc)
   );

   pec_ack_decide #(
      .BYTE_W(BYTE_W)
   ) u_decide (
      .clk        (clk),
      .rst_n      (rst_n),
      .rx_accept_i(rx_accept),
      .check_pec_i(check_pec),
      .byte_i     (byte_i),
      .crc_i      (crc),
      .ack_en_i   (ack_en_i),
      .err_clr_i  (err_clr_i),
      .ack_vld_o  (ack_vld_o),
      .nak_o      (nak_o),
      .err_o      (crc_err_o)
   );

   AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      ack_vld_o |-> ($past(byte_vld_i) && $past(rx_mode_i)))
      else $error("ack without byte"); // R11
   AST_ARM_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      pec_arm_i |=> pec_armed_o) else $error("arm not taken"); // R3

endmodule

// File: tb/tb_pec_rx_checker.sv
`timescale 1ns/1ps
module tb_pec_rx_checker;

   localparam logic [1:0] OP_IDLE  = 2'd0;
   localparam logic [1:0] OP_START = 2'd1;
   localparam logic [1:0] OP_BYTE  = 2'd2;
   localparam logic [1:0] OP_STOP  = 2'd3;
   localparam logic [1:0] K_DATA = 2'd0;
   localparam logic [1:0] K_GOOD = 2'd1;
   localparam logic [1:0] K_BAD  = 2'd2;

   // {op[19:18], rx[17], arm[16], ack_en[15], kind[14:13], data[12:5],
   //  exp_ackv[4], exp_nak[3], exp_err[2], pad[1:0]}
   localparam int NV = 16;
   localparam logic [19:0] VEC [NV] = '{
      {OP_START, 1'b0, 1'b0, 1'b1, K_DATA, 8'h00, 1'b0, 1'b0, 1'b0, 2'b00},
      {OP_BYTE,  1'b1, 1'b0, 1'b1, K_DATA, 8'hA6, 1'b1, 1'b0, 1'b0, 2'b00},
      {OP_BYTE,  1'b1, 1'b0, 1'b1, K_DATA, 8'h3C, 1'b1, 1'b0, 1'b0, 2'b00},
      {OP_IDLE,  1'b0, 1'b1, 1'b1, K_DATA, 8'h00, 1'b0, 1'b0, 1'b0, 2'b00},
      {OP_BYTE,  1'b1, 1'b0, 1'b1, K_GOOD, 8'h00, 1'b1, 1'b0, 1'b0, 2'b00},
      {OP_STOP,  1'b0, 1'b0, 1'b1, K_DATA, 8'h00, 1'b0, 1'b0, 1'b0, 2'b00},
      {OP_START, 1'b0, 1'b0, 1'b1, K_DATA, 8'h00, 1'b0, 1'b0, 1'b0, 2'b00},
      {OP_BYTE,  1'b1, 1'b0, 1'b1, K_DATA, 8'h50, 1'b1, 1'b0, 1'b0, 2'b00},
      {OP_BYTE,  1'b1, 1'b0, 1'b0, K_DATA, 8'h01, 1'b1, 1'b1, 1'b0, 2'b00},
      {OP_IDLE,  1'b0, 1'b1, 1'b1, K_DATA, 8'h00, 1'b0, 1'b0, 1'b0, 2'b00},
      {OP_BYTE,  1'b1, 1'b0, 1'b1, K_BAD,  8'h00, 1'b1, 1'b1, 1'b1, 2'b00},
      {OP_BYTE,  1'b1, 1'b0, 1'b1, K_DATA, 8'h02, 1'b1, 1'b0, 1'b1, 2'b00},
      {OP_STOP,  1'b0, 1'b0, 1'b1, K_DATA, 8'h00, 1'b0, 1'b0, 1'b1, 2'b00},
      {OP_BYTE,  1'b1, 1'b0, 1'b1, K_DATA, 8'h77, 1'b0, 1'b0, 1'b1, 2'b00},
      {OP_START, 1'b0, 1'b0, 1'b1, K_DATA, 8'h00, 1'b0, 1'b0, 1'b1, 2'b00},
      {OP_BYTE,  1'b0, 1'b0, 1'b1, K_DATA, 8'h99, 1'b0, 1'b0, 1'b1, 2'b00}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0, stop_i = 1'b0, byte_vld_i = 1'b0;
   logic [7:0] byte_i = 8'h00;
   logic       rx_mode_i = 1'b0, pec_arm_i = 1'b0, ack_en_i = 1'b1, err_clr_i = 1'b0;
   logic       ack_vld_o, nak_o, pec_armed_o, crc_err_o;

   int  n_run  = 0;
   int  n_fail = 0;
   bit  done   = 1'b0;

   logic [7:0] m_crc  = 8'h00;
   bit         m_busy = 1'b0;

   always #5 clk = ~clk;

   pec_rx_checker dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
      .byte_vld_i(byte_vld_i), .byte_i(byte_i), .rx_mode_i(rx_mode_i),
      .pec_arm_i(pec_arm_i), .ack_en_i(ack_en_i), .err_clr_i(err_clr_i),
      .ack_vld_o(ack_vld_o), .nak_o(nak_o), .pec_armed_o(pec_armed_o),
      .crc_err_o(crc_err_o)
   );

   function automatic logic [7:0] model_crc(input logic [7:0] c, input logic [7:0] d);
      logic [7:0] r;
      r = c ^ d;
      for (int i = 0; i < 8; i++) r = r[7] ? ((r << 1) ^ 8'h07) : (r << 1);
      return r;
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // One cycle of stimulus; outputs are sampled 1 ns after the edge.
   task automatic drive(input logic [1:0] op, input logic rx, input logic arm,
                        input logic ae, input logic [7:0] d, input logic clr);
      @(negedge clk);
      start_i    = (op == OP_START);
      stop_i     = (op == OP_STOP);
      byte_vld_i = (op == OP_BYTE);
      byte_i     = d;
      rx_mode_i  = rx;
      pec_arm_i  = arm;
      ack_en_i   = ae;
      err_clr_i  = clr;
      if (op == OP_START) begin
         m_crc = 8'h00; m_busy = 1'b1;
      end else if (op == OP_STOP) begin
         m_busy = 1'b0;
      end else if (op == OP_BYTE && m_busy) begin
         m_crc = model_crc(m_crc, d);
      end
      @(posedge clk);
      #1;
      start_i = 1'b0; stop_i = 1'b0; byte_vld_i = 1'b0;
      pec_arm_i = 1'b0; err_clr_i = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual running expected finished");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic [7:0] d;
      repeat (3) @(posedge clk);
      #1;
      // R11 reset state
      chk(ack_vld_o == 1'b0 && nak_o == 1'b0, "R11", "reset ack", ack_vld_o, 0);
      chk(pec_armed_o == 1'b0, "R4", "reset armed", pec_armed_o, 0);
      chk(crc_err_o == 1'b0, "R9", "reset err", crc_err_o, 0);
      @(negedge clk);
      rst_n = 1'b1;

      // Table walk: R1 R2 R3 R5 R6 R7 R8 R9 R10
      for (int v = 0; v < NV; v++) begin
         logic [19:0] e;
         e = VEC[v];
         d = e[12:5];
         if (e[14:13] == K_GOOD) d = m_crc;
         if (e[14:13] == K_BAD)  d = m_crc ^ 8'h01;
         drive(e[19:18], e[17], e[16], e[15], d, 1'b0);
         chk(ack_vld_o == e[4], "R6/R10", $sformatf("vec %0d ack_vld", v), ack_vld_o, e[4]);
         if (e[4])
            chk(nak_o == e[3], "R7/R8", $sformatf("vec %0d nak", v), nak_o, e[3]);
         chk(crc_err_o == e[2], "R8/R9", $sformatf("vec %0d err", v), crc_err_o, e[2]);
      end

      // R9 clear of sticky flag
      drive(OP_IDLE, 1'b0, 1'b0, 1'b1, 8'h00, 1'b1);
      chk(crc_err_o == 1'b0, "R9", "err cleared", crc_err_o, 0);

      // R3 arm read-back, R5 tx byte keeps arm and gets no ack
      drive(OP_IDLE, 1'b0, 1'b1, 1'b1, 8'h00, 1'b0);
      chk(pec_armed_o == 1'b1, "R3", "armed after pulse", pec_armed_o, 1);
      drive(OP_BYTE, 1'b0, 1'b0, 1'b1, 8'h5A, 1'b0);
      chk(ack_vld_o == 1'b0, "R5", "tx byte ack", ack_vld_o, 0);
      chk(pec_armed_o == 1'b1, "R5", "tx byte keeps arm", pec_armed_o, 1);
      chk(crc_err_o == 1'b0, "R5", "tx byte no compare", crc_err_o, 0);
      // check byte covers the tx bytes too (R1)
      drive(OP_BYTE, 1'b1, 1'b0, 1'b1, m_crc, 1'b0);
      chk(ack_vld_o == 1'b1 && nak_o == 1'b0, "R1", "pec over tx bytes", {ack_vld_o, nak_o}, 2);
      chk(pec_armed_o == 1'b0, "R3", "arm consumed", pec_armed_o, 0);
      chk(crc_err_o == 1'b0, "R7", "good pec no err", crc_err_o, 0);

      // R4 START clears arm
      drive(OP_IDLE, 1'b0, 1'b1, 1'b1, 8'h00, 1'b0);
      drive(OP_START, 1'b0, 1'b0, 1'b1, 8'h00, 1'b0);
      chk(pec_armed_o == 1'b0, "R4", "start disarms", pec_armed_o, 0);

      // R2 repeated START restarts the CRC
      drive(OP_BYTE, 1'b1, 1'b0, 1'b1, 8'h12, 1'b0);
      drive(OP_START, 1'b0, 1'b0, 1'b1, 8'h00, 1'b0);
      drive(OP_BYTE, 1'b1, 1'b0, 1'b1, 8'hC3, 1'b0);
      drive(OP_IDLE, 1'b0, 1'b1, 1'b1, 8'h00, 1'b0);
      drive(OP_BYTE, 1'b1, 1'b0, 1'b1, model_crc(8'h00, 8'hC3), 1'b0);
      chk(nak_o == 1'b0 && crc_err_o == 1'b0, "R2", "crc restart", {nak_o, crc_err_o}, 0);

      // R7 matching check byte with ack disabled -> NAK, no error
      drive(OP_IDLE, 1'b0, 1'b1, 1'b1, 8'h00, 1'b0);
      drive(OP_BYTE, 1'b1, 1'b0, 1'b0, m_crc, 1'b0);
      chk(ack_vld_o == 1'b1 && nak_o == 1'b1, "R7", "good pec ack disabled", {ack_vld_o, nak_o}, 3);
      chk(crc_err_o == 1'b0, "R7", "good pec ack disabled err", crc_err_o, 0);

      // R1 fixed check value: "123456789" -> 0xF4
      drive(OP_START, 1'b0, 1'b0, 1'b1, 8'h00, 1'b0);
      for (int i = 0; i < 9; i++) drive(OP_BYTE, 1'b1, 1'b0, 1'b1, 8'h31 + 8'(i), 1'b0);
      drive(OP_IDLE, 1'b0, 1'b1, 1'b1, 8'h00, 1'b0);
      drive(OP_BYTE, 1'b1, 1'b0, 1'b1, 8'hF4, 1'b0);
      chk(nak_o == 1'b0 && crc_err_o == 1'b0, "R1", "check value F4", {nak_o, crc_err_o}, 0);

      // R8 mismatch with ack disabled still NAK + error; R9 set beats clear
      drive(OP_IDLE, 1'b0, 1'b1, 1'b1, 8'h00, 1'b0);
      drive(OP_BYTE, 1'b1, 1'b0, 1'b0, m_crc ^ 8'h80, 1'b1);
      chk(nak_o == 1'b1, "R8", "bad pec nak", nak_o, 1);
      chk(crc_err_o == 1'b1, "R9", "set wins over clear", crc_err_o, 1);

      // R11 one-cycle ack strobe
      drive(OP_IDLE, 1'b0, 1'b0, 1'b1, 8'h00, 1'b0);
      chk(ack_vld_o == 1'b0, "R11", "ack strobe one cycle", ack_vld_o, 0);

      // R4 reset clears arm and error
      drive(OP_IDLE, 1'b0, 1'b1, 1'b1, 8'h00, 1'b0);
      @(negedge clk);
      rst_n = 1'b0;
      #2;
      chk(pec_armed_o == 1'b0 && crc_err_o == 1'b0, "R4", "reset clears",
          {pec_armed_o, crc_err_o}, 0);
      @(negedge clk);
      rst_n = 1'b1;

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule